// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit takes one bit of a 16-bit or 32-bit data word, chosen by a bit offset counted upward from the least significant bit, and reports the value that bit held in the carry flag. In the same operation it applies one of four write-back policies to the word. It can leave the word alone, force the chosen bit high, force it low, or invert it. A write-enable tells the surrounding datapath whether the modified word has to be stored back.

The offset comes either from an 8-bit immediate field or from a full-width register value. The unit reduces it modulo the operand width. Only the carry flag is defined after the operation. The other status flags pass through from the incoming flag vector unchanged, and a flags-valid mask marks carry as the only updated flag.

The unit is a single registered stage. A request presented with `req_valid` produces its results on the outputs one clock later, together with `res_valid`.

Top module: `btm_unit`

## Requirements
- R1: The offset selects the data bit with that index counted from the least significant end: an effective offset of k refers to `operand[k]`.
- R2: When `offset_src` is 0, the offset is the zero-extended 8-bit `imm_offset`. When it is 1, the offset is the full-width `reg_offset`.
- R3: `carry` and bit 0 of `flags_out` equal the chosen bit as it was in `operand` before any modification.
- R4: Opcode 00 (test) returns `result` equal to `operand` and holds `wr_en` at 0.
- R5: Opcode 01 (set) forces the chosen bit to 1. Opcode 10 (reset) forces it to 0. Opcode 11 (complement) inverts it. Every other bit of `result` equals `operand`.
- R6: `wr_en` is 1 for opcodes 01, 10 and 11.
- R7: With `size32` = 1 the effective offset is the low 5 bits of the selected offset. With `size32` = 0 it is the low 4 bits. All higher offset bits are ignored.
- R8: With `size32` = 0, `result[31:16]` equals `operand[31:16]` for every opcode.
- R9: `flags_out` bits 5..1 (overflow, sign, zero, aux-carry, parity) equal `flags_in` bits 5..1. `flags_mask` is 6'b000001 on a valid result.
- R10: Results appear one clock after `req_valid` is sampled high, with `res_valid` = 1. A cycle without a request, and the reset state, give `res_valid`, `wr_en` and `flags_mask` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| operand | input | 32 | Data word to test and modify |
| imm_offset | input | 8 | Immediate bit offset |
| reg_offset | input | 32 | Register bit offset |
| offset_src | input | 1 | 0 = immediate offset, 1 = register offset |
| size32 | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| op | input | 2 | 00 test, 01 set, 10 reset, 11 complement |
| flags_in | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| res_valid | output | 1 | Result valid |
| result | output | 32 | Updated data word |
| wr_en | output | 1 | Write-back required |
| carry | output | 1 | Old value of the chosen bit |
| flags_out | output | 6 | Flags with carry replaced |
| flags_mask | output | 6 | Flags updated by this operation |

## Verification
The hardest cases to reach are offsets whose bits above the width-selected field are non-zero. Random offsets seldom produce them with a clear expected wrap, and they expose an offset that is not reduced or is reduced by the wrong width. Directed cases therefore send large register offsets and immediates such as 8'hFF and 8'd20 in 16-bit mode, so that the wrapped index lands on a known bit. The random stream draws all 32 offset bits uniformly, which makes non-zero upper bits the common case and exercises the upper-half pass-through of 16-bit mode.

// File: rtl/btm_pkg.sv
package btm_pkg;
   typedef enum logic [1:0] {
      BTM_TEST  = 2'b00,
      BTM_SET   = 2'b01,
      BTM_CLR   = 2'b10,
      BTM_FLIP  = 2'b11
   } btm_op_e;

   localparam int BTM_FLAG_W = 6;
   localparam int BTM_CF_POS = 0;
endpackage

// File: rtl/btm_offset_sel.sv
module btm_offset_sel #(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int IMM_W    = 8,
   localparam int IDX_W   = $clog2(DATA_W),
   localparam int NIDX_W  = $clog2(NARROW_W)
) (
   input  logic [IMM_W-1:0]  imm_offset,
   input  logic [DATA_W-1:0] reg_offset,
   input  logic              offset_src,
   input  logic              size32,
   output logic [IDX_W-1:0]  bit_idx
);
   logic [DATA_W-1:0] raw_off;
   logic              unused_hi;

   initial begin
      assert (IMM_W >= IDX_W) else $error("immediate narrower than index");
      assert (DATA_W >= IMM_W) else $error("immediate wider than data");
   end

   always_comb begin
      raw_off = offset_src ? reg_offset : {{(DATA_W-IMM_W){1'b0}}, imm_offset};
      if (size32) bit_idx = raw_off[IDX_W-1:0];
      else        bit_idx = {{(IDX_W-NIDX_W){1'b0}}, raw_off[NIDX_W-1:0]};
   end

   assign unused_hi = ^raw_off[DATA_W-1:IDX_W];
endmodule

// File: rtl/btm_bit_mod.sv
module btm_bit_mod
   import btm_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [IDX_W-1:0]  bit_idx,
   input  btm_op_e           op,
   output logic [DATA_W-1:0] new_word,
   output logic              old_bit,
   output logic              write_back
);
   assign old_bit    = operand[bit_idx];
   assign write_back = (op != BTM_TEST);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic hit;
      assign hit = (bit_idx == IDX_W'(i));
      always_comb begin
         new_word[i] = operand[i];
         if (hit) begin
            unique case (op)
               BTM_TEST: new_word[i] = operand[i];
               BTM_SET:  new_word[i] = 1'b1;
               BTM_CLR:  new_word[i] = 1'b0;
               BTM_FLIP: new_word[i] = ~operand[i];
            endcase
         end
      end
   end
endmodule

// File: rtl/btm_flag_merge.sv
module btm_flag_merge #(
   parameter int FLAG_W = 6,
   parameter int CF_POS = 0
) (
   input  logic [FLAG_W-1:0] flags_in,
   input  logic              new_cf,
   output logic [FLAG_W-1:0] flags_out,
   output logic [FLAG_W-1:0] upd_mask
);
   initial begin
      assert (CF_POS < FLAG_W) else $error("carry position outside flag vector");
   end

   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      if (i == CF_POS) begin : g_cf
         assign flags_out[i] = new_cf;
         assign upd_mask[i]  = 1'b1;
      end else begin : g_keep
         assign flags_out[i] = flags_in[i];
         assign upd_mask[i]  = 1'b0;
      end
   end
endmodule

// File: rtl/btm_unit.sv
module btm_unit
   import btm_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int IMM_W    = 8,
   localparam int IDX_W   = $clog2(DATA_W),
   localparam int FLAG_W  = BTM_FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] operand,
   input  logic [IMM_W-1:0]  imm_offset,
   input  logic [DATA_W-1:0] reg_offset,
   input  logic              offset_src,
   input  logic              size32,
   input  logic [1:0]        op,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              res_valid,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              carry,
   output logic [FLAG_W-1:0] flags_out,
   output logic [FLAG_W-1:0] flags_mask
);
   initial begin
      assert (DATA_W == 2 * NARROW_W) else $error("wide width must be twice narrow width");
      assert ((1 << IDX_W) == DATA_W) else $error("data width must be a power of two");
   end

   logic [IDX_W-1:0]  bit_idx;
   logic [DATA_W-1:0] new_word;
   logic              old_bit;
   logic              write_back;
   logic [FLAG_W-1:0] flags_nx;
   logic [FLAG_W-1:0] mask_nx;
   btm_op_e           op_e;

   assign op_e = btm_op_e'(op);

   btm_offset_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .IMM_W(IMM_W)) i_off (
      .imm_offset (imm_offset),
      .reg_offset (reg_offset),
      .offset_src (offset_src),
      .size32     (size32),
      .bit_idx    (bit_idx)
   );

   btm_bit_mod #(.DATA_W(DATA_W)) i_mod (
      .operand    (operand),
      .bit_idx    (bit_idx),
      .op         (op_e),
      .new_word   (new_word),
      .old_bit    (old_bit),
      .write_back (write_back)
   );

   btm_flag_merge #(.FLAG_W(FLAG_W), .CF_POS(BTM_CF_POS)) i_flg (
      .flags_in  (flags_in),
      .new_cf    (old_bit),
      .flags_out (flags_nx),
      .upd_mask  (mask_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         result     <= '0;
         wr_en      <= 1'b0;
         carry      <= 1'b0;
         flags_out  <= '0;
         flags_mask <= '0;
      end else if (req_valid) begin
         res_valid  <= 1'b1;
         result     <= new_word;
         wr_en      <= write_back;
         carry      <= old_bit;
         flags_out  <= flags_nx;
         flags_mask <= mask_nx;
      end else begin
         res_valid  <= 1'b0;
         wr_en      <= 1'b0;
         flags_mask <= '0;
      end
   end

   // R4: test leaves the word as it was and requests no store
   a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == 2'b00) |=> (result == $past(operand) && !wr_en));

   // R5: at most one bit of the word changes, exactly one on complement
   a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($countones(result ^ $past(operand)) <= 1));
   a_r5_flip_one: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == 2'b11) |=> ($countones(result ^ $past(operand)) == 1));
   a_r5_set_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == 2'b01) |=> ((result & $past(operand)) == $past(operand)));
   a_r5_clr_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == 2'b10) |=> ((result | $past(operand)) == $past(operand)));

   // R6: every modifying opcode requests a store
   a_r6_wr_en: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op != 2'b00) |=> wr_en);

   // R8: narrow mode never touches the upper half
   a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !size32) |=> (result[DATA_W-1:NARROW_W] == $past(operand[DATA_W-1:NARROW_W])));

   // R9: non-carry flags pass through, mask names only carry
   a_r9_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (((flags_out ^ $past(flags_in)) & ~FLAG_W'(1 << BTM_CF_POS)) == '0
                     && $onehot0(flags_mask) && flags_mask[BTM_CF_POS]));

   // R3: carry out matches the flag-vector carry bit
   a_r3_carry_copy: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (flags_out[BTM_CF_POS] == carry));

   // R10: idle cycles carry no store request and no flag update
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && !wr_en && flags_mask == '0));
endmodule

// File: tb/test_btm_unit.sv
module test_btm_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [31:0] operand;
   logic [7:0]  imm_offset;
   logic [31:0] reg_offset;
   logic        offset_src;
   logic        size32;
   logic [1:0]  op;
   logic [5:0]  flags_in;
   logic        res_valid;
   logic [31:0] result;
   logic        wr_en;
   logic        carry;
   logic [5:0]  flags_out;
   logic [5:0]  flags_mask;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   btm_unit i_btm_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .operand(operand),
      .imm_offset(imm_offset), .reg_offset(reg_offset), .offset_src(offset_src),
      .size32(size32), .op(op), .flags_in(flags_in), .res_valid(res_valid),
      .result(result), .wr_en(wr_en), .carry(carry), .flags_out(flags_out),
      .flags_mask(flags_mask)
   );

   function automatic int ref_idx(bit s32, bit src, logic [7:0] imm, logic [31:0] rg);
      logic [31:0] raw;
      raw = src ? rg : {24'd0, imm};
      return s32 ? int'(raw[4:0]) : int'(raw[3:0]);
   endfunction

   function automatic logic [31:0] ref_word(logic [31:0] w, int k, logic [1:0] o);
      logic [31:0] r;
      r = w;
      case (o)
         2'b01: r[k] = 1'b1;
         2'b10: r[k] = 1'b0;
         2'b11: r[k] = ~w[k];
         default: r = w;
      endcase
      return r;
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic run_op(logic [31:0] w, logic [7:0] imm, logic [31:0] rg,
                         bit src, bit s32, logic [1:0] o, logic [5:0] fl, string tag);
      int k;
      @(negedge clk);
      req_valid = 1'b1; operand = w; imm_offset = imm; reg_offset = rg;
      offset_src = src; size32 = s32; op = o; flags_in = fl;
      k = ref_idx(s32, src, imm, rg);
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R10 res_valid"}, {31'd0, res_valid}, 32'd1);
      chk({tag, " R1 R2 R5 R7 R8 result"}, result, ref_word(w, k, o));
      chk({tag, " R3 carry"}, {31'd0, carry}, {31'd0, w[k]});
      chk({tag, " R4 R6 wr_en"}, {31'd0, wr_en}, {31'd0, (o != 2'b00)});
      chk({tag, " R9 flags"}, {26'd0, flags_out}, {26'd0, fl[5:1], w[k]});
      chk({tag, " R9 mask"}, {26'd0, flags_mask}, 32'd1);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; req_valid = 1'b0; operand = '0; imm_offset = '0;
      reg_offset = '0; offset_src = 1'b0; size32 = 1'b1; op = 2'b00; flags_in = '0;
      repeat (3) @(negedge clk);
      chk("R10 reset res_valid", {31'd0, res_valid}, 32'd0);
      chk("R10 reset wr_en", {31'd0, wr_en}, 32'd0);
      chk("R10 reset mask", {26'd0, flags_mask}, 32'd0);
      rst_n = 1'b1;

      // directed corners
      run_op(32'h8000_0000, 8'd31, 32'd0, 1'b0, 1'b1, 2'b00, 6'h2A, "top bit test");
      run_op(32'h0000_0001, 8'd0, 32'd0, 1'b0, 1'b1, 2'b10, 6'h3F, "bit0 reset");
      run_op(32'hFFFF_0000, 8'd15, 32'd0, 1'b0, 1'b0, 2'b01, 6'h00, "narrow top set");
      run_op(32'hFFFF_FFFF, 8'd20, 32'd0, 1'b0, 1'b0, 2'b11, 6'h15, "R7 narrow wrap 20");
      run_op(32'h0000_0000, 8'hFF, 32'd0, 1'b0, 1'b1, 2'b01, 6'h0E, "R7 imm FF wide");
      run_op(32'h1234_5678, 8'hFF, 32'hFFFF_FFE3, 1'b1, 1'b1, 2'b11, 6'h30, "R2 reg src");
      run_op(32'h1234_5678, 8'd3, 32'hFFFF_FFE9, 1'b0, 1'b1, 2'b00, 6'h30, "R2 imm src");
      run_op(32'hA5A5_A5A5, 8'd0, 32'h8000_001F, 1'b1, 1'b0, 2'b10, 6'h21, "R8 narrow reg");

      // idle cycle
      @(negedge clk);
      chk("R10 idle res_valid", {31'd0, res_valid}, 32'd0);
      chk("R10 idle wr_en", {31'd0, wr_en}, 32'd0);
      chk("R10 idle mask", {26'd0, flags_mask}, 32'd0);

      // constrained random
      for (int n = 0; n < 400; n++) begin
         run_op($urandom(), 8'($urandom()), $urandom(), 1'($urandom()),
                1'($urandom()), 2'($urandom()), 6'($urandom()), "random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule